// File: doc/BRIEF.md
# Flash Sector Write-Protection Gate

This block sits between the command decoder of a NOR-style flash array and its program and erase engines. It decides whether each program, erase or protection-bit request may proceed. Every request that is accepted gets exactly one answer: a single-cycle grant pulse or a single-cycle deny pulse. The array itself, the charge pumps, the command decoder and the supply sensing are outside the block. The low-supply condition arrives as a digital flag, and the write-protect pin arrives already synchronized; the board pull-up makes an unconnected pin read high.

Four sources of protection combine in a fixed order of precedence. A low supply denies everything. Next, a write-protect pin held low shields one outermost sector, and a build-time parameter picks whether that is the highest or the lowest sector. Next comes the persistent per-sector protection bit, supplied as a vector. Requests that change protection bits are checked only against a volatile lock. Software can set that lock, but only a hardware reset or a power-on reset clears it. A command sequence opens with a start strobe, which captures the pin level, and ends with the request.

Top module: `spg_gate`

## Requirements
- R1: A protection-bit write (kind code 2) is denied while `locked` is 1 and granted while it is 0, provided `lowSupply` is 0. Neither the pin nor the sector bits affect it.
- R2: A lock request (kind code 3) is granted and sets `locked` to 1. No request clears `locked`. It returns to 0 only when `rstN` or `porN` is driven low.
- R3: While the effective write-protect level is 0, a program (kind code 0) or an erase (kind code 1) to the outermost sector is denied, even if that sector's bit in `ppbVec` is 0.
- R4: With `OUTER_HIGH` = 1 the outermost sector is sector `NUM_SECTORS-1`. With `OUTER_HIGH` = 0 it is sector 0. Every other sector ignores the pin.
- R5: While the effective write-protect level is 1, a program or erase to any sector is denied when that sector's bit in `ppbVec` is 1 (protected) and granted when it is 0.
- R6: A `seqStart` pulse captures `wpPin`. The next request uses the captured level, whatever `wpPin` does in between. A request with no open sequence uses the live `wpPin`.
- R7: A request made while `lowSupply` is 1 is denied, whatever its kind. Such a request leaves `locked` unchanged. `forceRead` follows `lowSupply` one cycle later. A low supply also closes any open sequence, so its captured pin level is discarded.
- R8: After `porN` is released, requests get neither grant nor deny until a cycle arrives with `reqValid` at 0. A release of `rstN` alone imposes no such wait.
- R9: A request accepted at a clock edge produces exactly one of `grant` or `deny`, high for one cycle. It is registered at that same edge.
- R10: While either reset is low, `grant` and `deny` are 0, `locked` is 0 and `forceRead` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, asynchronous, active low |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| seqStart | input | 1 | Opens a command sequence and captures the pin level |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqKind | input | 2 | 0 program, 1 erase, 2 protection-bit write, 3 lock |
| reqSector | input | $clog2(NUM_SECTORS) | Decoded sector address |
| ppbVec | input | NUM_SECTORS | Persistent protection bits, 1 means protected |
| wpPin | input | 1 | Synchronized write-protect pin, 0 protects |
| lowSupply | input | 1 | Supply below the write threshold |
| grant | output | 1 | One-cycle grant pulse |
| deny | output | 1 | One-cycle deny pulse |
| locked | output | 1 | Volatile protection lock, 1 means locked |
| forceRead | output | 1 | Forces the array back to read mode |

## Verification
`grant`, `deny` and any change to `locked` are registered at the edge that samples `reqValid`. `forceRead` appears at the edge after `lowSupply` changes. The bench drives inputs on falling edges and holds each request for a single cycle. It reads every result at the next falling edge, half a period after the edge that registered it. The sector, kind, pin and protection-bit sweep runs on two instances at once, one for each `OUTER_HIGH` setting. The power-up wait, the sequence capture and the low-supply abort each use their own short cycle-exact scenario.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic [1:0] {
    KIND_PROG = 2'd0,
    KIND_ERASE = 2'd1,
    KIND_PPB = 2'd2,
    KIND_LOCK = 2'd3
  } reqKindT;

  typedef struct packed {
    logic grantStb;
    logic denyStb;
    logic lockSetStb;
  } ctrlStrbT;
endpackage

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
(
  input  logic       clk,
  input  logic       anyRstN,
  input  logic       porN,
  input  logic       seqStart,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       wpPin,
  input  logic       lowSupply,
  input  logic       isOuter,
  input  logic       ppbHit,
  input  logic       locked,
  output ctrlStrbT   strb,
  output logic       pwrHold,
  output logic       inSeq
);
  logic wpHeld;
  logic wpEff;
  logic accept;
  reqKindT kind;

  assign kind = reqKindT'(reqKind);
  assign accept = reqValid && !pwrHold;
  assign wpEff = inSeq ? wpHeld : wpPin;

  // a write strobe held through power-up is never a command
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) pwrHold <= 1'b1;
    else if (!reqValid) pwrHold <= 1'b0;
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      inSeq <= 1'b0;
      wpHeld <= 1'b1;
    end else if (lowSupply || accept) begin
      inSeq <= 1'b0;
    end else if (seqStart && !pwrHold) begin
      inSeq <= 1'b1;
      wpHeld <= wpPin;
    end
  end

  always_comb begin
    strb = '0;
    if (accept) begin
      if (lowSupply) begin
        strb.denyStb = 1'b1;
      end else begin
        unique case (kind)
          KIND_PROG, KIND_ERASE: begin
            if ((isOuter && !wpEff) || ppbHit) strb.denyStb = 1'b1;
            else strb.grantStb = 1'b1;
          end
          KIND_PPB: begin
            if (locked) strb.denyStb = 1'b1;
            else strb.grantStb = 1'b1;
          end
          KIND_LOCK: begin
            strb.grantStb = 1'b1;
            strb.lockSetStb = 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/spg_datapath.sv
module spg_datapath
  import spg_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter bit OUTER_HIGH = 1'b1,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   anyRstN,
  input  ctrlStrbT               strb,
  input  logic [SEC_W-1:0]       reqSector,
  input  logic [NUM_SECTORS-1:0] ppbVec,
  input  logic                   lowSupply,
  output logic                   isOuter,
  output logic                   ppbHit,
  output logic                   grant,
  output logic                   deny,
  output logic                   locked,
  output logic                   forceRead
);
  localparam logic [SEC_W-1:0] TOP_SEC = SEC_W'(NUM_SECTORS - 1);

  generate
    if (OUTER_HIGH) begin : gOuterHigh
      assign isOuter = (reqSector == TOP_SEC);
    end else begin : gOuterLow
      assign isOuter = (reqSector == '0);
    end
  endgenerate

  assign ppbHit = ppbVec[reqSector];

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      grant <= 1'b0;
      deny <= 1'b0;
      locked <= 1'b0;
      forceRead <= 1'b1;
    end else begin
      grant <= strb.grantStb;
      deny <= strb.denyStb;
      forceRead <= lowSupply;
      if (strb.lockSetStb) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/spg_gate.sv
module spg_gate
  import spg_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter bit OUTER_HIGH = 1'b1,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   porN,
  input  logic                   seqStart,
  input  logic                   reqValid,
  input  logic [1:0]             reqKind,
  input  logic [SEC_W-1:0]       reqSector,
  input  logic [NUM_SECTORS-1:0] ppbVec,
  input  logic                   wpPin,
  input  logic                   lowSupply,
  output logic                   grant,
  output logic                   deny,
  output logic                   locked,
  output logic                   forceRead
);
  logic anyRstN;
  logic isOuter;
  logic ppbHit;
  logic pwrHold;
  logic inSeq;
  ctrlStrbT strb;

  assign anyRstN = rstN && porN;

  spg_ctrl uCtrl (
    .clk(clk), .anyRstN(anyRstN), .porN(porN), .seqStart(seqStart),
    .reqValid(reqValid), .reqKind(reqKind), .wpPin(wpPin),
    .lowSupply(lowSupply), .isOuter(isOuter), .ppbHit(ppbHit),
    .locked(locked), .strb(strb), .pwrHold(pwrHold), .inSeq(inSeq)
  );

  spg_datapath #(.NUM_SECTORS(NUM_SECTORS), .OUTER_HIGH(OUTER_HIGH)) uDp (
    .clk(clk), .anyRstN(anyRstN), .strb(strb), .reqSector(reqSector),
    .ppbVec(ppbVec), .lowSupply(lowSupply), .isOuter(isOuter),
    .ppbHit(ppbHit), .grant(grant), .deny(deny), .locked(locked),
    .forceRead(forceRead)
  );
endmodule

// File: rtl/spg_chk.sv
module spg_chk #(
  parameter int NUM_SECTORS = 8,
  parameter bit OUTER_HIGH = 1'b1,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             porN,
  input logic             reqValid,
  input logic [1:0]       reqKind,
  input logic [SEC_W-1:0] reqSector,
  input logic             wpPin,
  input logic             lowSupply,
  input logic             grant,
  input logic             deny,
  input logic             locked,
  input logic             forceRead,
  input logic             pwrHold,
  input logic             inSeq
);
  localparam logic [SEC_W-1:0] OUTER_SEC = OUTER_HIGH ? SEC_W'(NUM_SECTORS - 1) : '0;

  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    $onehot0({grant, deny}));

  // R9
  answered_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (reqValid && !pwrHold) |=> (grant || deny));

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    locked |=> locked);

  // R1
  ppb_locked_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (reqValid && !pwrHold && locked && reqKind == 2'd2) |=> (deny && !grant));

  // R3
  wp_outer_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (reqValid && !pwrHold && !inSeq && !wpPin && !reqKind[1] && reqSector == OUTER_SEC)
      |=> !grant);

  // R7
  low_supply_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (reqValid && !pwrHold && lowSupply) |=> (deny && $stable(locked)));

  // R7
  force_read_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    lowSupply |=> forceRead);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (reqValid && pwrHold) |=> !(grant || deny));
endmodule

bind spg_gate spg_chk #(.NUM_SECTORS(NUM_SECTORS), .OUTER_HIGH(OUTER_HIGH)) uChk (
  .clk(clk), .rstN(rstN), .porN(porN), .reqValid(reqValid), .reqKind(reqKind),
  .reqSector(reqSector), .wpPin(wpPin), .lowSupply(lowSupply), .grant(grant),
  .deny(deny), .locked(locked), .forceRead(forceRead), .pwrHold(pwrHold),
  .inSeq(inSeq)
);

// File: tb/sim_spg_gate.sv
`timescale 1ns/1ps
module sim_spg_gate;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porN = 1'b0;
  logic seqStart = 1'b0;
  logic reqValid = 1'b1;
  logic [1:0] reqKind = 2'd0;
  logic [2:0] reqSector = 3'd0;
  logic [NS-1:0] ppbVec = '0;
  logic wpPin = 1'b1;
  logic lowSupply = 1'b0;
  logic g0, d0, l0, f0, g1, d1, l1, f1;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spg_gate #(.NUM_SECTORS(NS), .OUTER_HIGH(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .porN(porN), .seqStart(seqStart), .reqValid(reqValid),
    .reqKind(reqKind), .reqSector(reqSector), .ppbVec(ppbVec), .wpPin(wpPin),
    .lowSupply(lowSupply), .grant(g0), .deny(d0), .locked(l0), .forceRead(f0)
  );

  spg_gate #(.NUM_SECTORS(NS), .OUTER_HIGH(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .porN(porN), .seqStart(seqStart), .reqValid(reqValid),
    .reqKind(reqKind), .reqSector(reqSector), .ppbVec(ppbVec), .wpPin(wpPin),
    .lowSupply(lowSupply), .grant(g1), .deny(d1), .locked(l1), .forceRead(f1)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // one request, one cycle; result read at the following falling edge
  task automatic doReq(input logic [1:0] k, input logic [2:0] s);
    @(negedge clk);
    reqValid = 1'b1;
    reqKind = k;
    reqSector = s;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic openSeq();
    @(negedge clk);
    seqStart = 1'b1;
    @(negedge clk);
    seqStart = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    // R10: reset state, with a write strobe held low through power-up
    repeat (3) @(negedge clk);
    chk("R10 reset u0", {g0, d0, l0, f0}, 4'b0001);
    chk("R10 reset u1", {g1, d1, l1, f1}, 4'b0001);
    rstN = 1'b1;
    porN = 1'b1;
    reqKind = 2'd2;
    // R8: strobe still held after power-on release is not a command
    repeat (2) begin
      @(negedge clk);
      chk("R8 no answer while held", {g0, d0, g1, d1}, 4'b0000);
    end
    reqValid = 1'b0;
    @(negedge clk);
    chk("R7 forceRead follows low supply", {f0, f1, 2'b00}, 4'b0000);

    // R3 R4 R5: sweep sector, kind, pin, own protection bit
    for (int s = 0; s < NS; s++) begin
      for (int k = 0; k < 2; k++) begin
        for (int w = 0; w < 2; w++) begin
          for (int p = 0; p < 2; p++) begin
            logic e0, e1;
            wpPin = w[0];
            ppbVec = p[0] ? (NS'(1) << s) : ~(NS'(1) << s);
            doReq(k[1:0], s[2:0]);
            e0 = ((s == NS - 1) && (w == 0)) || (p == 1);
            e1 = ((s == 0) && (w == 0)) || (p == 1);
            chk("R3 R4 R5 R9 high-outer", {g0, d0, 2'b00}, {!e0, e0, 2'b00});
            chk("R3 R4 R5 R9 low-outer", {g1, d1, 2'b00}, {!e1, e1, 2'b00});
          end
        end
      end
    end
    ppbVec = '0;
    wpPin = 1'b1;
    @(negedge clk);
    chk("R9 single-cycle pulse", {g0, d0, g1, d1}, 4'b0000);

    // R6: pin captured at sequence start
    wpPin = 1'b0;
    openSeq();
    wpPin = 1'b1;
    doReq(2'd0, 3'd7);
    chk("R6 captured low denies", {g0, d0, 2'b00}, 4'b0100);
    wpPin = 1'b1;
    openSeq();
    wpPin = 1'b0;
    doReq(2'd1, 3'd0);
    chk("R6 captured high grants", {g1, d1, 2'b00}, 4'b1000);
    wpPin = 1'b1;

    // R7: low supply in the middle of a sequence
    wpPin = 1'b0;
    openSeq();
    lowSupply = 1'b1;
    doReq(2'd3, 3'd2);
    chk("R7 low supply denies lock", {g0, d0, l0, f0}, 4'b0101);
    lowSupply = 1'b0;
    wpPin = 1'b1;
    @(negedge clk);
    chk("R7 forceRead drops", {f0, f1, 2'b00}, 4'b0000);
    doReq(2'd0, 3'd7);
    chk("R7 sequence discarded", {g0, d0, l0, 1'b0}, 4'b1000);

    // R1 R2: lock and protection-bit writes
    doReq(2'd2, 3'd4);
    chk("R1 unlocked write grants", {g0, d0, l0, 1'b0}, 4'b1000);
    doReq(2'd3, 3'd4);
    chk("R2 lock sets", {g0, d0, l0, l1}, 4'b1011);
    doReq(2'd2, 3'd4);
    chk("R1 locked write denies", {g0, d0, l0, 1'b0}, 4'b0110);
    doReq(2'd3, 3'd1);
    chk("R2 lock stays set", {g1, d1, l1, 1'b0}, 4'b1010);

    // R2 R8: hardware reset clears lock and imposes no wait
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b1;
    reqKind = 2'd2;
    @(negedge clk);
    chk("R2 hw reset clears lock", {l0, l1, 2'b00}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 no wait after hw reset", {g0, d0, g1, d1}, 4'b1010);

    // R2: power cycle clears lock too
    doReq(2'd3, 3'd0);
    chk("R2 relock", {l0, l1, 2'b00}, 4'b1100);
    porN = 1'b0;
    @(negedge clk);
    chk("R10 power-on reset state", {g0, d0, l0, f0}, 4'b0001);
    porN = 1'b1;
    @(negedge clk);
    doReq(2'd2, 3'd3);
    chk("R1 R2 write after power cycle", {g0, d0, l0, 1'b0}, 4'b1000);

    done = 1'b1;
    finishRun();
  end
endmodule